// File: doc/BRIEF.md
# Two-Dimensional Stream Transfer Sequencer with End-of-Packet Marking

This block sequences a rectangular memory-to-stream transfer. It takes one descriptor: a first row address, a row pitch, a byte count per row and a row count. From that it issues one burst request per row, each with the row's start address and the number of bus beats the row needs. While a row's data beats pass on the outgoing stream, it drives an end-of-packet qualifier that tells the stream where to place TLAST. The read engine, burst splitting and the stream-to-memory direction belong to other blocks.

Two descriptor bits shape the marker. A placement mode puts it on the last beat of every row (line mode) or only on the last beat of the final row (frame mode). An enable bit can suppress it entirely. Lengths use the minus-one convention. The row pitch is a multiple of the bus width, so the low address bits stay fixed across rows. The next row is requested only once the final beat of the current row has been accepted.

Top module: `tl2d_gen`

## Requirements
- R1: The descriptor port is ready only when no transfer is active. The first row request appears in the cycle after the descriptor is accepted, and it carries the start address.
- R2: Each row request carries a beat count equal to floor(X/BUS_BYTES)+1, where X is the per-row byte count minus one.
- R3: A transfer issues exactly Y+1 row requests, where Y is the row count minus one. Request n carries start address + n*pitch, modulo 2^ADDR_W.
- R4: A row request is never pending while row data beats are in progress. The next row is requested only after the final beat of the current row is accepted (valid and ready both high).
- R5: In frame mode (mode bit 0), the end-of-packet qualifier is high only on the final beat of the final row. The block is idle in the cycle after that beat.
- R6: In line mode (mode bit 1), the end-of-packet qualifier is high on the final beat of every row.
- R7: When the enable bit is 0, the end-of-packet qualifier stays low for the whole transfer.
- R8: With Y=0, the qualifier lands on the final beat in both modes.
- R9: Beat handshakes while no transfer is active are ignored. The qualifier stays low and the descriptor port stays ready.
- R10: After reset, the descriptor port is ready, no row request is pending and the qualifier is low.
- R11: Changing the descriptor inputs after acceptance has no effect on the transfer in progress.
- R12: A pending row request holds its address and beat count until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Descriptor offered |
| cmd_ready | output | 1 | Block idle, descriptor accepted |
| cmd_addr | input | ADDR_W | First row byte address |
| cmd_stride | input | ADDR_W | Row pitch in bytes, bus-aligned |
| cmd_x_len | input | LEN_W | Bytes per row minus one |
| cmd_y_len | input | ROWS_W | Rows minus one |
| cmd_tlast_en | input | 1 | Enable for the end-of-packet qualifier |
| cmd_line_mode | input | 1 | 1: mark every row end, 0: mark frame end only |
| req_valid | output | 1 | Row burst request pending |
| req_ready | input | 1 | Row burst request accepted |
| req_addr | output | ADDR_W | Row start address |
| req_beats | output | BEAT_W | Beats in the row |
| beat_valid | input | 1 | Stream beat valid (observed) |
| beat_ready | input | 1 | Stream beat ready (observed) |
| beat_last | output | 1 | TLAST qualifier for the current beat |

## Verification
The first row request is due one clock after the descriptor handshake. Each later row request is due one clock after the handshake of the previous row's final beat. The end-of-packet qualifier is combinational with the beat it marks, so it is valid in the same cycle as that beat's handshake. The bench drives inputs just after each rising edge and compares at the falling edge. A scoreboard queues the expected requests and per-beat markers before a descriptor is offered. The monitor pops one entry exactly when a request or beat handshake is visible at the falling edge. Because of this, stalls on either handshake shift when a comparison happens without changing what is expected.

// File: rtl/tl2d_pkg.sv
package tl2d_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_BEAT = 2'd2
   } tl2d_state_e;

   function automatic int unsigned tl2d_log2(input int unsigned v);
      int unsigned r;
      r = 0;
      while ((1 << r) < v) r++;
      return r;
   endfunction
endpackage

// File: rtl/tl2d_ctrl.sv
module tl2d_ctrl
   import tl2d_pkg::*;
#(
   parameter int ROWS_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_fire,
   input  logic              req_fire,
   input  logic              beat_fire,
   input  logic              at_row_end,
   input  logic [ROWS_W-1:0] y_len,
   input  logic              tlast_en,
   input  logic              line_mode,
   output tl2d_state_e       state,
   output logic              last_row,
   output logic              row_done,
   output logic              mark_en,
   output logic              mark_line
);
   tl2d_state_e       state_q, state_d;
   logic [ROWS_W-1:0] row_q;
   logic [ROWS_W-1:0] rows_m1_q;
   logic              en_q;
   logic              line_q;

   assign state     = state_q;
   assign last_row  = (row_q == rows_m1_q);
   assign row_done  = (state_q == ST_BEAT) && beat_fire && at_row_end;
   assign mark_en   = en_q;
   assign mark_line = line_q;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (cmd_fire) state_d = ST_REQ;
         ST_REQ:  if (req_fire) state_d = ST_BEAT;
         ST_BEAT: if (row_done) state_d = last_row ? ST_IDLE : ST_REQ;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         row_q     <= '0;
         rows_m1_q <= '0;
         en_q      <= 1'b0;
         line_q    <= 1'b0;
      end else begin
         state_q <= state_d;
         if (cmd_fire) begin
            row_q     <= '0;
            rows_m1_q <= y_len;
            en_q      <= tlast_en;
            line_q    <= line_mode;
         end else if (row_done && !last_row) begin
            row_q <= row_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/tl2d_addr_gen.sv
module tl2d_addr_gen #(
   parameter int ADDR_W = 32,
   parameter int SH     = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              advance,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [ADDR_W-1:0] stride,
   output logic [ADDR_W-1:0] row_addr
);
   localparam int HI_W = ADDR_W - SH;

   logic [HI_W-1:0] hi_q;
   logic [HI_W-1:0] step_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_q   <= '0;
         step_q <= '0;
      end else if (load) begin
         hi_q   <= start_addr[ADDR_W-1:SH];
         step_q <= stride[ADDR_W-1:SH];
      end else if (advance) begin
         hi_q <= hi_q + step_q;
      end
   end

   generate
      if (SH == 0) begin : g_full
         assign row_addr = hi_q;
      end else begin : g_split
         logic [SH-1:0] lo_q;
         always_ff @(posedge clk) begin
            if (!rst_n)    lo_q <= '0;
            else if (load) lo_q <= start_addr[SH-1:0];
         end
         assign row_addr = {hi_q, lo_q};
      end
   endgenerate
endmodule

// File: rtl/tl2d_beat_cnt.sv
module tl2d_beat_cnt #(
   parameter int LEN_W  = 16,
   parameter int SH     = 3,
   parameter int BEAT_W = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [LEN_W-1:0]  x_len,
   input  logic              restart,
   input  logic              step,
   output logic [BEAT_W-1:0] beats,
   output logic              at_end
);
   logic [BEAT_W-1:0] last_idx_q;
   logic [BEAT_W-1:0] last_idx_d;
   logic [BEAT_W-1:0] cnt_q;

   generate
      if (SH == 0) begin : g_byte_bus
         assign last_idx_d = {1'b0, x_len};
      end else begin : g_wide_bus
         assign last_idx_d = {1'b0, x_len[LEN_W-1:SH]};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last_idx_q <= '0;
         cnt_q      <= '0;
      end else begin
         if (load)         last_idx_q <= last_idx_d;
         if (restart)      cnt_q <= '0;
         else if (step)    cnt_q <= cnt_q + 1'b1;
      end
   end

   assign beats  = last_idx_q + 1'b1;
   assign at_end = (cnt_q == last_idx_q);
endmodule

// File: rtl/tl2d_gen.sv
module tl2d_gen
   import tl2d_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int LEN_W     = 16,
   parameter int ROWS_W    = 16,
   parameter int BUS_BYTES = 8,
   parameter int SH        = tl2d_log2(BUS_BYTES),
   parameter int BEAT_W    = LEN_W - SH + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [ADDR_W-1:0] cmd_stride,
   input  logic [LEN_W-1:0]  cmd_x_len,
   input  logic [ROWS_W-1:0] cmd_y_len,
   input  logic              cmd_tlast_en,
   input  logic              cmd_line_mode,
   output logic              req_valid,
   input  logic              req_ready,
   output logic [ADDR_W-1:0] req_addr,
   output logic [BEAT_W-1:0] req_beats,
   input  logic              beat_valid,
   input  logic              beat_ready,
   output logic              beat_last
);
   generate
      if ((BUS_BYTES < 1) || ((BUS_BYTES & (BUS_BYTES - 1)) != 0)) begin : g_bad_bus
         $error("tl2d_gen: BUS_BYTES must be a power of two");
      end
      if (SH >= LEN_W) begin : g_bad_len
         $error("tl2d_gen: LEN_W must exceed log2(BUS_BYTES)");
      end
      if (SH >= ADDR_W) begin : g_bad_addr
         $error("tl2d_gen: ADDR_W must exceed log2(BUS_BYTES)");
      end
      if (BEAT_W != LEN_W - SH + 1) begin : g_bad_beat
         $error("tl2d_gen: BEAT_W must be LEN_W - log2(BUS_BYTES) + 1");
      end
   endgenerate

   tl2d_state_e state;
   logic        last_row;
   logic        row_done;
   logic        mark_en;
   logic        mark_line;
   logic        at_row_end;
   logic        cmd_fire;
   logic        req_fire;
   logic        beat_fire;
   logic        in_beats;

   assign cmd_ready = (state == ST_IDLE);
   assign req_valid = (state == ST_REQ);
   assign in_beats  = (state == ST_BEAT);
   assign cmd_fire  = cmd_valid && cmd_ready;
   assign req_fire  = req_valid && req_ready;
   assign beat_fire = beat_valid && beat_ready && in_beats;

   tl2d_ctrl #(.ROWS_W(ROWS_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_fire   (cmd_fire),
      .req_fire   (req_fire),
      .beat_fire  (beat_fire),
      .at_row_end (at_row_end),
      .y_len      (cmd_y_len),
      .tlast_en   (cmd_tlast_en),
      .line_mode  (cmd_line_mode),
      .state      (state),
      .last_row   (last_row),
      .row_done   (row_done),
      .mark_en    (mark_en),
      .mark_line  (mark_line)
   );

   tl2d_addr_gen #(.ADDR_W(ADDR_W), .SH(SH)) u_addr (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (cmd_fire),
      .advance    (row_done && !last_row),
      .start_addr (cmd_addr),
      .stride     (cmd_stride),
      .row_addr   (req_addr)
   );

   tl2d_beat_cnt #(.LEN_W(LEN_W), .SH(SH), .BEAT_W(BEAT_W)) u_beats (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (cmd_fire),
      .x_len   (cmd_x_len),
      .restart (req_fire),
      .step    (beat_fire),
      .beats   (req_beats),
      .at_end  (at_row_end)
   );

   assign beat_last = mark_en && in_beats && at_row_end && (mark_line || last_row);
endmodule

// File: rtl/tl2d_gen_chk.sv
module tl2d_gen_chk #(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 16,
   parameter int SH     = 3,
   parameter int BEAT_W = 14
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic              cmd_ready,
   input logic [ADDR_W-1:0] cmd_addr,
   input logic [LEN_W-1:0]  cmd_x_len,
   input logic              cmd_tlast_en,
   input logic              cmd_line_mode,
   input logic              req_valid,
   input logic              req_ready,
   input logic [ADDR_W-1:0] req_addr,
   input logic [BEAT_W-1:0] req_beats,
   input logic              beat_valid,
   input logic              beat_ready,
   input logic              beat_last
);
   logic             en_seen;
   logic             line_seen;
   logic [LEN_W-1:0] x_seen;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_seen   <= 1'b0;
         line_seen <= 1'b0;
         x_seen    <= '0;
      end else if (cmd_valid && cmd_ready) begin
         en_seen   <= cmd_tlast_en;
         line_seen <= cmd_line_mode;
         x_seen    <= cmd_x_len;
      end
   end

   // R1
   first_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready) |=> (req_valid && req_addr == $past(cmd_addr)));

   // R1
   busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> !cmd_ready);

   // R2
   beat_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (req_beats == BEAT_W'((x_seen >> SH) + 1)));

   // R4
   no_req_in_beats_chk: assert property (@(posedge clk) disable iff (!rst_n)
      beat_last |-> !req_valid);

   // R5
   frame_end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid && beat_ready && beat_last && !line_seen) |=> cmd_ready);

   // R7
   mark_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_seen |-> !beat_last);

   // R9
   idle_no_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready |-> !beat_last);

   // R12
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_beats)));
endmodule

bind tl2d_gen tl2d_gen_chk #(
   .ADDR_W (ADDR_W),
   .LEN_W  (LEN_W),
   .SH     (SH),
   .BEAT_W (BEAT_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cmd_valid     (cmd_valid),
   .cmd_ready     (cmd_ready),
   .cmd_addr      (cmd_addr),
   .cmd_x_len     (cmd_x_len),
   .cmd_tlast_en  (cmd_tlast_en),
   .cmd_line_mode (cmd_line_mode),
   .req_valid     (req_valid),
   .req_ready     (req_ready),
   .req_addr      (req_addr),
   .req_beats     (req_beats),
   .beat_valid    (beat_valid),
   .beat_ready    (beat_ready),
   .beat_last     (beat_last)
);

// File: tb/tb_tl2d_gen.sv
module tb_tl2d_gen;
   localparam int ADDR_W = 32;
   localparam int LEN_W  = 16;
   localparam int ROWS_W = 16;
   localparam int BUSB   = 8;
   localparam int BEAT_W = 14;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cmd_valid = 1'b0;
   logic              cmd_ready;
   logic [ADDR_W-1:0] cmd_addr = '0;
   logic [ADDR_W-1:0] cmd_stride = '0;
   logic [LEN_W-1:0]  cmd_x_len = '0;
   logic [ROWS_W-1:0] cmd_y_len = '0;
   logic              cmd_tlast_en = 1'b0;
   logic              cmd_line_mode = 1'b0;
   logic              req_valid;
   logic              req_ready = 1'b0;
   logic [ADDR_W-1:0] req_addr;
   logic [BEAT_W-1:0] req_beats;
   logic              beat_valid = 1'b0;
   logic              beat_ready = 1'b0;
   logic              beat_last;

   int  checks = 0;
   int  fails  = 0;
   int  pend   = 0;
   int  cycles = 0;
   bit  stray  = 1'b0;
   bit  jitter = 1'b0;
   bit  done   = 1'b0;
   logic [15:0] lfsr = 16'hACE1;

   typedef struct { logic [ADDR_W-1:0] addr; int beats; } req_t;
   typedef struct { bit last; string tag; } mark_t;
   req_t  req_q[$];
   mark_t mark_q[$];

   bit                held = 1'b0;
   logic [ADDR_W-1:0] held_addr;

   always #4 clk = ~clk;

   tl2d_gen #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .ROWS_W(ROWS_W), .BUS_BYTES(BUSB)) dut (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
      .cmd_stride(cmd_stride), .cmd_x_len(cmd_x_len), .cmd_y_len(cmd_y_len),
      .cmd_tlast_en(cmd_tlast_en), .cmd_line_mode(cmd_line_mode),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .req_beats(req_beats), .beat_valid(beat_valid), .beat_ready(beat_ready),
      .beat_last(beat_last)
   );

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Responder: drives handshakes just after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         if (!stray) begin
            req_ready  = jitter ? lfsr[0] : 1'b1;
            beat_valid = (pend > 0) && (jitter ? lfsr[1] : 1'b1);
            beat_ready = jitter ? lfsr[2] | lfsr[3] : 1'b1;
         end
      end
   end

   // Monitor: compares at the falling edge
   initial begin
      forever begin
         @(negedge clk);
         cycles++;
         if (!rst_n) continue;
         if (held) begin
            check(req_valid && req_addr == held_addr, "R12 request held",
                  {31'd0, req_valid, req_addr}, {32'd1, held_addr});
            held = 1'b0;
         end
         if (req_valid && !req_ready) begin
            held = 1'b1;
            held_addr = req_addr;
         end
         if (req_valid && req_ready) begin
            if (req_q.size() == 0) begin
               check(1'b0, "R3 unexpected row request", req_addr, 0);
            end else begin
               req_t e;
               e = req_q.pop_front();
               check(req_addr == e.addr, "R3 row address", req_addr, e.addr);
               check(req_beats == BEAT_W'(e.beats), "R2 beat count", req_beats, e.beats);
               pend += e.beats;
            end
         end
         if (stray) begin
            check(beat_last == 1'b0 && cmd_ready == 1'b1, "R9 stray beat ignored",
                  {beat_last, cmd_ready}, 2'b01);
         end else if (beat_valid && beat_ready) begin
            if (mark_q.size() == 0) begin
               check(1'b0, "R4 unexpected beat", 1, 0);
            end else begin
               mark_t m;
               m = mark_q.pop_front();
               check(beat_last == m.last, m.tag, beat_last, m.last);
               pend--;
            end
         end
      end
   end

   // Watchdog
   initial begin
      wait (cycles > 150000);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=<150000 cycles", cycles);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   task automatic run_xfer(input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] s,
                           input int x, input int y, input bit en, input bit line,
                           input string tag);
      int nb;
      nb = (x + BUSB) / BUSB;
      for (int r = 0; r <= y; r++) begin
         req_t e;
         e.addr  = a + ADDR_W'(r) * s;
         e.beats = nb;
         req_q.push_back(e);
         for (int b = 0; b < nb; b++) begin
            mark_t m;
            m.last = en && (b == nb - 1) && (line || r == y);
            m.tag  = tag;
            mark_q.push_back(m);
         end
      end
      @(posedge clk);
      #1;
      cmd_valid     = 1'b1;
      cmd_addr      = a;
      cmd_stride    = s;
      cmd_x_len     = LEN_W'(x);
      cmd_y_len     = ROWS_W'(y);
      cmd_tlast_en  = en;
      cmd_line_mode = line;
      do @(negedge clk); while (!cmd_ready);
      @(posedge clk);
      #1;
      // R11: scramble the descriptor inputs while the transfer runs
      cmd_valid     = 1'b0;
      cmd_addr      = ~a;
      cmd_stride    = s + 32'h40;
      cmd_x_len     = LEN_W'(x + 17);
      cmd_y_len     = ROWS_W'(y + 3);
      cmd_tlast_en  = ~en;
      cmd_line_mode = ~line;
      do @(negedge clk); while (!(cmd_ready && req_q.size() == 0 && mark_q.size() == 0));
      check(pend == 0, "R11 transfer completed as latched", pend, 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      @(negedge clk);
      // R10
      check(cmd_ready == 1'b1 && req_valid == 1'b0 && beat_last == 1'b0, "R10 reset state",
            {cmd_ready, req_valid, beat_last}, 3'b100);

      run_xfer(32'h0000_1000, 32'h40, 23, 2, 1'b1, 1'b0, "R5 frame mode marker");
      run_xfer(32'h0000_1000, 32'h40, 23, 2, 1'b1, 1'b1, "R6 line mode marker");
      run_xfer(32'h0000_2008, 32'h80, 7, 0, 1'b1, 1'b0, "R8 single row frame mode");
      run_xfer(32'h0000_2008, 32'h80, 7, 0, 1'b1, 1'b1, "R8 single row line mode");
      jitter = 1'b1;
      run_xfer(32'h0000_3000, 32'h20, 8, 3, 1'b0, 1'b1, "R7 marker disabled");
      run_xfer(32'hFFFF_FF00, 32'h100, 0, 1, 1'b1, 1'b1, "R6 wrap line mode");
      run_xfer(32'h0001_0004, 32'h200, 63, 20, 1'b1, 1'b0, "R5 tall frame stalled");
      jitter = 1'b0;

      // R9: beat handshakes while idle
      @(posedge clk);
      #1;
      stray = 1'b1;
      beat_valid = 1'b1;
      beat_ready = 1'b1;
      repeat (4) @(negedge clk);
      @(posedge clk);
      #1;
      beat_valid = 1'b0;
      stray = 1'b0;
      run_xfer(32'h0000_0100, 32'h10, 15, 1, 1'b1, 1'b1, "R9 transfer after stray beats");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule